// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block follows a linked list of 16-byte region descriptors held in memory. Software or a packet interpreter places the chain in memory and then pulses `start` with the address of the first descriptor and the direction the command expects. For every descriptor the walker asks a downstream data mover for one burst, giving the buffer address, the byte count and the direction. It stops after the descriptor flagged as final and reports the outcome on a one-cycle `done` pulse with an end code.

Descriptors are read one 32-bit little-endian word at a time through a simple request/valid read port. Each descriptor holds a buffer address, a length counted in 8-byte units, a flag byte, a mode byte carrying the device timing mode, and a pointer to the next descriptor. The flag byte carries a direction bit, an ordering bit and an end-of-chain bit. A descriptor with zero length produces no burst. A read error or a direction that disagrees with the command ends the walk early.

The controller has five named states. IDLE leaves on `start`. FETCH reads the descriptor words. ADVANCE decides whether to skip, issue or follow the chain. ISSUE holds a burst request until it is acknowledged. REPORT is the single cycle of `done`. The transitions are: IDLE→FETCH on start; FETCH→REPORT on a read error or a direction conflict; FETCH→ADVANCE once the needed words are in; ADVANCE→ISSUE for a non-zero length; ADVANCE→FETCH for a skipped non-final descriptor; ADVANCE→REPORT for a skipped final one; ISSUE→FETCH on acknowledge of a non-final descriptor; ISSUE→REPORT on acknowledge of the final one; REPORT→IDLE always.

Top module: `sg_chain_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `mem_rd_req`, `xfer_req` and `done` are all 0.
- R2: A descriptor is read as words at pointer+0, +4, +8 and +12, in that order, with one read outstanding at a time. `mem_rd_req` and `mem_rd_addr` stay unchanged until `mem_rd_valid`.
- R3: Word 0 is the buffer address and word 1 the length in 8-byte units. In word 2, bits 7:0 are the flag byte and bits 11:8 are the timing mode. Word 3 is the next pointer. A burst request presents `xfer_addr` = word 0, `xfer_bytes` = word 1 × 8 and `xfer_mode` = word 2 bits 11:8.
- R4: Flag bit 5 set means host to device and is driven on `xfer_h2d`. Flag bit 4 (ordering) has no effect on the walk or the request.
- R5: When flag bit 7 (final) is set, word 3 is not read. After that descriptor's burst the walk ends with `done` and `end_code` = 0 (OK).
- R6: For a descriptor without bit 7, the walk continues at the address held in its word 3.
- R7: A descriptor with length 0 issues no burst request. The walk continues, or ends with code 0 if that descriptor is final.
- R8: A read answered with `mem_rd_err` ends the walk in the next cycle with `done` and `end_code` = 1 (bus error). No further read or burst follows.
- R9: If flag bit 5 of a descriptor differs from `start_h2d`, the walk ends with `end_code` = 2 (direction conflict) and no burst is issued for that descriptor.
- R10: `start` is ignored while `busy` is 1.
- R11: `xfer_req` stays high with address, byte count, direction and mode unchanged until `xfer_ack`.
- R12: `busy` is 1 from the cycle after an accepted `start` through the `done` cycle. `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (taken only when idle) |
| start_ptr | input | 32 | Address of the first descriptor |
| start_h2d | input | 1 | Expected direction, 1 = host to device |
| busy | output | 1 | Walk in progress |
| mem_rd_req | output | 1 | Descriptor word read request |
| mem_rd_addr | output | 32 | Byte address of the requested word |
| mem_rd_valid | input | 1 | Read answer present |
| mem_rd_data | input | 32 | Read word, little-endian |
| mem_rd_err | input | 1 | Read answer is an error |
| xfer_req | output | 1 | Burst request to the data mover |
| xfer_addr | output | 32 | Burst buffer address |
| xfer_bytes | output | 35 | Burst length in bytes |
| xfer_h2d | output | 1 | Burst direction, 1 = host to device |
| xfer_mode | output | 4 | Device timing mode for the burst |
| xfer_ack | input | 1 | Mover accepted the burst |
| done | output | 1 | One-cycle end-of-walk pulse |
| end_code | output | 2 | 0 OK, 1 bus error, 2 direction conflict |

## Verification
The hardest cases to reach are the ones that arise deep inside a chain. One is a read error on the fetch of a later descriptor, after an earlier burst has already gone out. Another is a zero-length final descriptor reached only by following two pointers. The bench builds these chains in its memory model, placing the bad next pointer outside the mapped range so the error comes from the walker's own pointer-following. It also delays the mover's acknowledge by several cycles, so that request stability and a `start` arriving mid-walk are exercised while the walker waits.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    localparam int DESC_WORDS    = 4;
    localparam int FLAG_H2D_BIT  = 5;
    localparam int FLAG_LAST_BIT = 7;
    localparam int MODE_LSB      = 8;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_FETCH,
        WS_ADVANCE,
        WS_ISSUE,
        WS_REPORT
    } walk_state_e;

    typedef enum logic [1:0] {
        END_OK   = 2'd0,
        END_BUS  = 2'd1,
        END_DIR  = 2'd2
    } end_code_e;

endpackage

// File: rtl/sgw_desc_capture.sv
module sgw_desc_capture
    import sgw_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int MODE_W = 4,
    localparam int IDX_W = $clog2(DESC_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [WORD_W-1:0] cap_word,
    output logic [WORD_W-1:0] buf_addr,
    output logic [WORD_W-1:0] len_units,
    output logic [MODE_W-1:0] mode,
    output logic              h2d,
    output logic              last,
    output logic [WORD_W-1:0] next_ptr
);

    logic [WORD_W-1:0] word_q [DESC_WORDS];

    for (genvar w = 0; w < DESC_WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[w] <= '0;
            end else if (cap_en && cap_idx == IDX_W'(w)) begin
                word_q[w] <= cap_word;
            end
        end
    end

    assign buf_addr  = word_q[0];
    assign len_units = word_q[1];
    assign mode      = word_q[2][MODE_LSB +: MODE_W];
    assign h2d       = word_q[2][FLAG_H2D_BIT];
    assign last      = word_q[2][FLAG_LAST_BIT];
    assign next_ptr  = word_q[3];

    // ordering bit, packet-length and reserved bytes carry no walk behaviour
    logic unused_fields;
    assign unused_fields = ^{word_q[2][WORD_W-1:MODE_LSB+MODE_W],
                             word_q[2][6], word_q[2][4:0]};

endmodule

// File: rtl/sgw_end_report.sv
module sgw_end_report
    import sgw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_en,
    input  end_code_e  set_code,
    output logic [1:0] code_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= END_OK;
        end else if (set_en) begin
            code_q <= set_code;
        end
    end

endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
    import sgw_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int LEN_SHIFT = 3,
    parameter int MODE_W    = 4,
    localparam int BYTES_W  = WORD_W + LEN_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WORD_W-1:0]  start_ptr,
    input  logic               start_h2d,
    output logic               busy,
    output logic               mem_rd_req,
    output logic [WORD_W-1:0]  mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [WORD_W-1:0]  mem_rd_data,
    input  logic               mem_rd_err,
    output logic               xfer_req,
    output logic [WORD_W-1:0]  xfer_addr,
    output logic [BYTES_W-1:0] xfer_bytes,
    output logic               xfer_h2d,
    output logic [MODE_W-1:0]  xfer_mode,
    input  logic               xfer_ack,
    output logic               done,
    output logic [1:0]         end_code
);

    localparam int IDX_W = $clog2(DESC_WORDS);
    localparam logic [IDX_W-1:0] IDX_FLAGS = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_NEXT  = IDX_W'(3);

    walk_state_e       state, state_nx;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] cur_ptr;
    logic              dir_q;

    logic [WORD_W-1:0] d_addr, d_len, d_next;
    logic [MODE_W-1:0] d_mode;
    logic              d_h2d, d_last;
    logic              word_ok, len_zero, follow;
    logic              rep_set;
    end_code_e         rep_code;

    assign word_ok  = (state == WS_FETCH) && mem_rd_valid && !mem_rd_err;
    assign len_zero = (d_len == '0);

    sgw_desc_capture #(.WORD_W(WORD_W), .MODE_W(MODE_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (word_ok),
        .cap_idx   (idx),
        .cap_word  (mem_rd_data),
        .buf_addr  (d_addr),
        .len_units (d_len),
        .mode      (d_mode),
        .h2d       (d_h2d),
        .last      (d_last),
        .next_ptr  (d_next)
    );

    sgw_end_report u_rep (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (rep_set),
        .set_code (rep_code),
        .code_q   (end_code)
    );

    // next state and end code selection
    always_comb begin
        state_nx = state;
        rep_set  = 1'b0;
        rep_code = END_OK;
        follow   = 1'b0;
        unique case (state)
            WS_IDLE: begin
                if (start) state_nx = WS_FETCH;
            end
            WS_FETCH: begin
                if (mem_rd_valid) begin
                    if (mem_rd_err) begin
                        state_nx = WS_REPORT;
                        rep_set  = 1'b1;
                        rep_code = END_BUS;
                    end else if (idx == IDX_FLAGS) begin
                        if (mem_rd_data[FLAG_H2D_BIT] != dir_q) begin
                            state_nx = WS_REPORT;
                            rep_set  = 1'b1;
                            rep_code = END_DIR;
                        end else if (mem_rd_data[FLAG_LAST_BIT]) begin
                            state_nx = WS_ADVANCE;
                        end
                    end else if (idx == IDX_NEXT) begin
                        state_nx = WS_ADVANCE;
                    end
                end
            end
            WS_ADVANCE: begin
                if (!len_zero) begin
                    state_nx = WS_ISSUE;
                end else if (d_last) begin
                    state_nx = WS_REPORT;
                    rep_set  = 1'b1;
                end else begin
                    state_nx = WS_FETCH;
                    follow   = 1'b1;
                end
            end
            WS_ISSUE: begin
                if (xfer_ack) begin
                    if (d_last) begin
                        state_nx = WS_REPORT;
                        rep_set  = 1'b1;
                    end else begin
                        state_nx = WS_FETCH;
                        follow   = 1'b1;
                    end
                end
            end
            WS_REPORT: state_nx = WS_IDLE;
            default:   state_nx = WS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WS_IDLE;
        else        state <= state_nx;
    end

    // walk pointer, word index and expected direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ptr <= '0;
            idx     <= '0;
            dir_q   <= 1'b0;
        end else if (state == WS_IDLE && start) begin
            cur_ptr <= start_ptr;
            idx     <= '0;
            dir_q   <= start_h2d;
        end else if (follow) begin
            cur_ptr <= d_next;
            idx     <= '0;
        end else if (word_ok) begin
            idx <= idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy        = (state != WS_IDLE);
        mem_rd_req  = (state == WS_FETCH);
        mem_rd_addr = cur_ptr + {{(WORD_W-IDX_W-2){1'b0}}, idx, 2'b00};
        xfer_req    = (state == WS_ISSUE);
        xfer_addr   = d_addr;
        xfer_bytes  = {d_len, {LEN_SHIFT{1'b0}}};
        xfer_h2d    = d_h2d;
        xfer_mode   = d_mode;
        done        = (state == WS_REPORT);
    end

endmodule

// File: rtl/sgw_checker.sv
module sgw_checker #(
    parameter int WORD_W  = 32,
    parameter int BYTES_W = 35,
    parameter int MODE_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               mem_rd_req,
    input logic [WORD_W-1:0]  mem_rd_addr,
    input logic               mem_rd_valid,
    input logic               mem_rd_err,
    input logic               xfer_req,
    input logic [WORD_W-1:0]  xfer_addr,
    input logic [BYTES_W-1:0] xfer_bytes,
    input logic               xfer_h2d,
    input logic [MODE_W-1:0]  xfer_mode,
    input logic               xfer_ack,
    input logic               done,
    input logic [1:0]         end_code
);

    assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr));

    assert_no_empty_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> xfer_bytes != '0);

    assert_bus_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && mem_rd_valid && mem_rd_err |=> done && end_code == 2'd1 && !mem_rd_req);

    assert_busy_needs_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_burst_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_addr) && $stable(xfer_bytes)
                                  && $stable(xfer_h2d) && $stable(xfer_mode));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_while_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

bind sg_chain_walker sgw_checker #(
    .WORD_W (WORD_W),
    .BYTES_W(BYTES_W),
    .MODE_W (MODE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_valid(mem_rd_valid),
    .mem_rd_err  (mem_rd_err),
    .xfer_req    (xfer_req),
    .xfer_addr   (xfer_addr),
    .xfer_bytes  (xfer_bytes),
    .xfer_h2d    (xfer_h2d),
    .xfer_mode   (xfer_mode),
    .xfer_ack    (xfer_ack),
    .done        (done),
    .end_code    (end_code)
);

// File: tb/sg_chain_walker_tb.sv
module sg_chain_walker_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_ptr = '0;
    logic        start_h2d = 1'b0;
    logic        busy;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_rd_err = 1'b0;
    logic        xfer_req;
    logic [31:0] xfer_addr;
    logic [34:0] xfer_bytes;
    logic        xfer_h2d;
    logic [3:0]  xfer_mode;
    logic        xfer_ack = 1'b0;
    logic        done;
    logic [1:0]  end_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    sg_chain_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
        .start_h2d(start_h2d), .busy(busy), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err),
        .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_bytes(xfer_bytes),
        .xfer_h2d(xfer_h2d), .xfer_mode(xfer_mode), .xfer_ack(xfer_ack),
        .done(done), .end_code(end_code)
    );

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem [64];
    logic [31:0] rd_log [64];
    int          rd_cnt = 0;
    logic [31:0] xf_addr [16];
    logic [34:0] xf_bytes [16];
    logic        xf_h2d [16];
    logic [3:0]  xf_mode [16];
    int          xf_cnt = 0;
    int          ack_wait = 0;
    logic [1:0]  got_code;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // memory model: answers one cycle after seeing a request
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_valid) begin
                mem_rd_valid = 1'b0;
                mem_rd_err   = 1'b0;
            end else if (mem_rd_req) begin
                if (rd_cnt < 64) rd_log[rd_cnt] = mem_rd_addr;
                rd_cnt++;
                if (mem_rd_addr >= 32'h100) begin
                    mem_rd_err  = 1'b1;
                    mem_rd_data = '0;
                end else begin
                    mem_rd_data = mem[mem_rd_addr[7:2]];
                end
                mem_rd_valid = 1'b1;
            end
        end
    end

    // mover model: records each burst, acknowledges after ack_wait cycles
    initial begin
        bit pending = 0;
        int waited = 0;
        forever begin
            @(negedge clk);
            if (xfer_ack) begin
                xfer_ack = 1'b0;
            end else if (xfer_req) begin
                if (!pending) begin
                    pending = 1;
                    waited  = 0;
                    if (xf_cnt < 16) begin
                        xf_addr[xf_cnt]  = xfer_addr;
                        xf_bytes[xf_cnt] = xfer_bytes;
                        xf_h2d[xf_cnt]   = xfer_h2d;
                        xf_mode[xf_cnt]  = xfer_mode;
                    end
                end else begin
                    waited++;
                    chk(xfer_addr == xf_addr[xf_cnt] && xfer_bytes == xf_bytes[xf_cnt] &&
                        xfer_h2d == xf_h2d[xf_cnt] && xfer_mode == xf_mode[xf_cnt],
                        "R11 burst fields held", longint'(xfer_addr), longint'(xf_addr[xf_cnt]));
                end
                if (waited >= ack_wait) begin
                    xfer_ack = 1'b1;
                    pending  = 0;
                    xf_cnt++;
                end
            end
        end
    end

    task automatic clear_all();
        for (int i = 0; i < 64; i++) mem[i] = '0;
        rd_cnt = 0;
        xf_cnt = 0;
        ack_wait = 0;
    endtask

    task automatic put_desc(input int base, input logic [31:0] addr, input logic [31:0] len,
                            input logic [7:0] flags, input logic [7:0] mode_byte,
                            input logic [31:0] nxt);
        mem[(base >> 2) + 0] = addr;
        mem[(base >> 2) + 1] = len;
        mem[(base >> 2) + 2] = {16'h0000, mode_byte, flags};
        mem[(base >> 2) + 3] = nxt;
    endtask

    task automatic pulse_start(input logic [31:0] ptr, input logic dir);
        @(negedge clk);
        start_ptr = ptr;
        start_h2d = dir;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R12 done reached", longint'(done), 1);
        got_code = end_code;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R12 done one cycle then idle",
            longint'({done, busy}), 0);
    endtask

    task automatic run_walk(input logic [31:0] ptr, input logic dir);
        pulse_start(ptr, dir);
        chk(busy == 1'b1, "R12 busy after start", longint'(busy), 1);
        wait_done();
    endtask

    task automatic t_reset();
        chk(busy == 0 && mem_rd_req == 0 && xfer_req == 0 && done == 0,
            "R1 outputs in reset", longint'({busy, mem_rd_req, xfer_req, done}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && mem_rd_req == 0 && xfer_req == 0 && done == 0,
            "R1 outputs after reset", longint'({busy, mem_rd_req, xfer_req, done}), 0);
    endtask

    task automatic t_single();
        clear_all();
        put_desc(32'h00, 32'h0000_1000, 32'd4, 8'hB0, 8'h5A, 32'hDEAD_BEEC);
        run_walk(32'h00, 1'b1);
        chk(rd_cnt == 3, "R5 final skips next word", rd_cnt, 3);
        chk(rd_log[0] == 32'h0 && rd_log[1] == 32'h4 && rd_log[2] == 32'h8,
            "R2 word order", longint'(rd_log[2]), 32'h8);
        chk(xf_cnt == 1, "R5 one burst", xf_cnt, 1);
        chk(xf_addr[0] == 32'h1000 && xf_bytes[0] == 35'd32, "R3 address and bytes",
            longint'(xf_bytes[0]), 32);
        chk(xf_mode[0] == 4'hA, "R3 mode low nibble", longint'(xf_mode[0]), 4'hA);
        chk(xf_h2d[0] == 1'b1, "R4 direction with ordering bit set", longint'(xf_h2d[0]), 1);
        chk(got_code == 2'd0, "R5 end OK", longint'(got_code), 0);
    endtask

    task automatic t_chain();
        logic [31:0] exp_rd [11] = '{32'h40, 32'h44, 32'h48, 32'h4C, 32'h80, 32'h84,
                                     32'h88, 32'h8C, 32'h20, 32'h24, 32'h28};
        bit rd_ok = 1;
        clear_all();
        ack_wait = 3;
        put_desc(32'h40, 32'h0000_2000, 32'd1,    8'h00, 8'h03, 32'h80);
        put_desc(32'h80, 32'h0000_3000, 32'h10,   8'h10, 8'h04, 32'h20);
        put_desc(32'h20, 32'h0000_4000, 32'd2,    8'h80, 8'hF6, 32'h0);
        run_walk(32'h40, 1'b0);
        for (int i = 0; i < 11; i++) if (rd_log[i] != exp_rd[i]) rd_ok = 0;
        chk(rd_cnt == 11 && rd_ok, "R6 pointers followed, R2 order", rd_cnt, 11);
        chk(xf_cnt == 3, "R6 three bursts", xf_cnt, 3);
        chk(xf_addr[0] == 32'h2000 && xf_addr[1] == 32'h3000 && xf_addr[2] == 32'h4000,
            "R6 burst addresses", longint'(xf_addr[2]), 32'h4000);
        chk(xf_bytes[0] == 35'd8 && xf_bytes[1] == 35'd128 && xf_bytes[2] == 35'd16,
            "R3 byte counts", longint'(xf_bytes[1]), 128);
        chk(xf_mode[0] == 4'h3 && xf_mode[1] == 4'h4 && xf_mode[2] == 4'h6,
            "R3 modes", longint'(xf_mode[2]), 6);
        chk(xf_h2d[0] == 0 && xf_h2d[1] == 0 && xf_h2d[2] == 0, "R4 device to host",
            longint'(xf_h2d[1]), 0);
        chk(got_code == 2'd0, "R5 chain end OK", longint'(got_code), 0);
    endtask

    task automatic t_zero();
        clear_all();
        put_desc(32'h40, 32'h0000_5000, 32'd3, 8'h20, 8'h01, 32'h60);
        put_desc(32'h60, 32'h0000_5800, 32'd0, 8'h20, 8'h01, 32'h80);
        put_desc(32'h80, 32'h0000_5C00, 32'd0, 8'hA0, 8'h01, 32'h0);
        run_walk(32'h40, 1'b1);
        chk(xf_cnt == 1, "R7 zero length gives no burst", xf_cnt, 1);
        chk(xf_bytes[0] == 35'd24, "R7 remaining burst length", longint'(xf_bytes[0]), 24);
        chk(rd_cnt == 11, "R7 walk continues past empty descriptor", rd_cnt, 11);
        chk(got_code == 2'd0, "R7 empty final ends OK", longint'(got_code), 0);
    endtask

    task automatic t_buserr();
        clear_all();
        put_desc(32'h00, 32'h0000_6000, 32'd5, 8'h00, 8'h02, 32'h200);
        run_walk(32'h00, 1'b0);
        chk(got_code == 2'd1, "R8 bus error code", longint'(got_code), 1);
        chk(xf_cnt == 1, "R8 earlier burst kept", xf_cnt, 1);
        chk(rd_cnt == 5 && rd_log[4] == 32'h200, "R8 failing read", rd_cnt, 5);
        repeat (10) @(negedge clk);
        chk(rd_cnt == 5 && xf_cnt == 1 && busy == 0, "R8 nothing after error",
            rd_cnt, 5);
    endtask

    task automatic t_dir();
        clear_all();
        put_desc(32'h00, 32'h0000_7000, 32'd4, 8'hA0, 8'h02, 32'h0);
        run_walk(32'h00, 1'b0);
        chk(got_code == 2'd2, "R9 direction conflict code", longint'(got_code), 2);
        chk(xf_cnt == 0, "R9 no burst", xf_cnt, 0);
        chk(rd_cnt == 3, "R9 stops at flag word", rd_cnt, 3);
    endtask

    task automatic t_busy_start();
        bit rd_ok = 1;
        clear_all();
        ack_wait = 6;
        put_desc(32'h00, 32'h0000_1000, 32'd4, 8'h80, 8'h01, 32'h0);
        put_desc(32'h40, 32'h0000_7000, 32'd4, 8'h80, 8'h01, 32'h0);
        pulse_start(32'h00, 1'b0);
        repeat (2) @(negedge clk);
        pulse_start(32'h40, 1'b0);
        wait_done();
        repeat (10) @(negedge clk);
        for (int i = 0; i < rd_cnt && i < 64; i++) if (rd_log[i] >= 32'h40) rd_ok = 0;
        chk(xf_cnt == 1 && xf_addr[0] == 32'h1000, "R10 second start ignored",
            longint'(xf_addr[0]), 32'h1000);
        chk(rd_cnt == 3 && rd_ok, "R10 no reads of ignored chain", rd_cnt, 3);
        chk(busy == 0, "R10 idle afterwards", longint'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        t_single();
        t_chain();
        t_zero();
        t_buserr();
        t_dir();
        t_busy_start();
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule